// File: doc/BRIEF.md
# Time-Triggered Slot Dispatcher

This block keeps a small table of message slots for a time-triggered network and tells the surrounding logic when a slot's instant has come. Each slot carries a period, given as the index of a single bit of the global time word, and a phase, which is the offset inside that period. Because every period is a power of two of the base time unit, a slot recurs whenever the time bits below its period bit equal its phase. Bits at and above the period bit play no part in the comparison.

A slot is either periodic or sporadic. A periodic slot fires each time its instant recurs. A sporadic slot keeps its place in the schedule but fires only while an event is waiting for it. When it fires, that event is consumed. Every slot also has an interrupt-enable bit and a transfer-mode bit. Both are reported alongside the trigger.

The comparison runs only on a cycle in which the global time word differs from the value it held at the previous clock edge. When more than one slot matches on such a cycle, the lowest-numbered slot is reported. Every other matching slot is marked as a schedule conflict.

Top module: `tt_sched_dispatch`

## Requirements
- R1: While reset is held and on the first cycle after it, trig_valid, irq, trig_dma and conflict are 0. Every slot comes out of reset disabled, with no event pending.
- R2: Slot s matches on a cycle if all of the following hold: time_in differs from the value sampled at the previous edge; the slot is enabled; and time_in bits [p-1:0] equal phase bits [p-1:0], where p is the slot's period index. Bits at and above p are ignored. With p=0 the slot matches on every time change.
- R3: Match results appear on the outputs at the clock edge that ends the cycle in which time_in was presented, and they last for exactly one cycle.
- R4: No trigger is produced for a cycle in which time_in equals the previously sampled value.
- R5: A disabled slot never triggers and never appears in conflict.
- R6: An enabled periodic slot (sporadic bit 0) triggers on every recurrence of its instant.
- R7: An evt_set[s] pulse marks slot s pending from the next cycle onward. A sporadic slot (sporadic bit 1) matches only while it is pending. Its pending mark is cleared when it is the reported trigger, unless evt_set[s] is high in that same cycle.
- R8: When several slots match, trig_idx holds the lowest matching index, and conflict has a 1 for every other matching slot. A sporadic slot that loses in this way stays pending.
- R9: irq is 1 together with trig_valid only when the reported slot's interrupt-enable bit is 1.
- R10: trig_dma equals the reported slot's transfer-mode bit while trig_valid is 1, and is 0 otherwise.
- R11: A write (wr_en=1) to slot wr_idx replaces its period, phase, enable, sporadic, interrupt-enable and transfer-mode fields. The new values are used from the following cycle's comparison onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| time_in | input | TIME_W | Global harmonic time word |
| wr_en | input | 1 | Descriptor write strobe |
| wr_idx | input | IDX_W | Slot to write |
| wr_period | input | PER_W | Period bit index for the written slot |
| wr_phase | input | TIME_W | Phase for the written slot |
| wr_enable | input | 1 | Slot enable |
| wr_sporadic | input | 1 | 1 = sporadic slot, 0 = periodic slot |
| wr_irq_en | input | 1 | Interrupt enable for the slot |
| wr_dma | input | 1 | Transfer-mode bit carried with the trigger |
| evt_set | input | NUM_SLOTS | Per-slot pulse marking an event pending |
| trig_valid | output | 1 | A slot fired in the previous cycle |
| trig_idx | output | IDX_W | Index of the fired slot |
| trig_dma | output | 1 | Transfer-mode bit of the fired slot |
| irq | output | 1 | Interrupt pulse |
| conflict | output | NUM_SLOTS | Slots that also matched but were not reported |

## Verification
The bench builds the block with its defaults: eight slots and a 64-bit time word. Periods are drawn mostly from indices 0 to 5, so instants recur every few ticks and overlapping slots, and therefore conflicts, occur often. The time word moves in steps of zero to two, so held-time cycles and matches on every change are both exercised. Random descriptor rewrites and event pulses fall on the same cycles as matches, which covers the case where a pending mark is consumed and set again in the same cycle.

// File: rtl/tt_sched_pkg.sv
package tt_sched_pkg;

   // Per-slot configuration bits
   typedef struct packed {
      logic en;      // slot takes part in comparison
      logic spor;    // 1 = fires only when an event is pending
      logic irq_en;  // raise irq when this slot fires
      logic dma;     // transfer-mode bit reported with the trigger
   } tt_cfg_t;

endpackage

// File: rtl/tt_desc_store.sv
module tt_desc_store
   import tt_sched_pkg::*;
#(
   parameter int NUM_SLOTS = 8,
   parameter int TIME_W    = 64,
   parameter int PER_W     = 6,
   parameter int IDX_W     = 3
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_en,
   input  logic [IDX_W-1:0]                   wr_idx,
   input  logic [PER_W-1:0]                   wr_per,
   input  logic [TIME_W-1:0]                  wr_phase,
   input  tt_cfg_t                            wr_cfg,
   output logic [NUM_SLOTS-1:0][PER_W-1:0]    per_o,
   output logic [NUM_SLOTS-1:0][TIME_W-1:0]   phase_o,
   output tt_cfg_t [NUM_SLOTS-1:0]            cfg_o
);

   generate
      for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
         logic sel;
         assign sel = wr_en && (wr_idx == IDX_W'(s));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               per_o[s]   <= '0;
               phase_o[s] <= '0;
               cfg_o[s]   <= '0;
            end else if (sel) begin
               per_o[s]   <= wr_per;
               phase_o[s] <= wr_phase;
               cfg_o[s]   <= wr_cfg;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/tt_slot_match.sv
module tt_slot_match
   import tt_sched_pkg::*;
#(
   parameter int TIME_W = 64,
   parameter int PER_W  = 6
) (
   input  logic [TIME_W-1:0] time_in,
   input  logic              tick,
   input  logic [PER_W-1:0]  per,
   input  logic [TIME_W-1:0] phase,
   input  tt_cfg_t           cfg,
   input  logic              pend,
   output logic              hit
);

   logic [TIME_W-1:0] low_mask;
   logic              at_instant;
   logic              armed;

   // bits strictly below the period bit take part in the compare
   assign low_mask   = ~({TIME_W{1'b1}} << per);
   assign at_instant = (((time_in ^ phase) & low_mask) == '0);
   assign armed      = !cfg.spor || pend;
   assign hit        = tick && cfg.en && at_instant && armed;

endmodule

// File: rtl/tt_prio_pick.sv
module tt_prio_pick #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx,
   output logic [N-1:0]     grant,
   output logic [N-1:0]     others
);

   always_comb begin
      grant = '0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            grant    = '0;
            grant[i] = 1'b1;
            idx      = IDX_W'(i);
         end
      end
   end

   assign any    = |req;
   assign others = req & ~grant;

endmodule

// File: rtl/tt_sched_dispatch.sv
module tt_sched_dispatch
   import tt_sched_pkg::*;
#(
   parameter  int NUM_SLOTS = 8,
   parameter  int TIME_W    = 64,
   localparam int IDX_W     = $clog2(NUM_SLOTS),
   localparam int PER_W     = $clog2(TIME_W)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [TIME_W-1:0]    time_in,
   input  logic                 wr_en,
   input  logic [IDX_W-1:0]     wr_idx,
   input  logic [PER_W-1:0]     wr_period,
   input  logic [TIME_W-1:0]    wr_phase,
   input  logic                 wr_enable,
   input  logic                 wr_sporadic,
   input  logic                 wr_irq_en,
   input  logic                 wr_dma,
   input  logic [NUM_SLOTS-1:0] evt_set,
   output logic                 trig_valid,
   output logic [IDX_W-1:0]     trig_idx,
   output logic                 trig_dma,
   output logic                 irq,
   output logic [NUM_SLOTS-1:0] conflict
);

   // elaboration-time parameter checks
   generate
      if (NUM_SLOTS < 2) begin : g_bad_slots
         $error("tt_sched_dispatch: NUM_SLOTS must be at least 2");
      end
      if (TIME_W < 2) begin : g_bad_time
         $error("tt_sched_dispatch: TIME_W must be at least 2");
      end
   endgenerate

   // descriptor table
   tt_cfg_t                           wr_cfg;
   logic    [NUM_SLOTS-1:0][PER_W-1:0]  per_q;
   logic    [NUM_SLOTS-1:0][TIME_W-1:0] phase_q;
   tt_cfg_t [NUM_SLOTS-1:0]            cfg_q;

   assign wr_cfg = '{en: wr_enable, spor: wr_sporadic, irq_en: wr_irq_en, dma: wr_dma};

   tt_desc_store #(
      .NUM_SLOTS (NUM_SLOTS),
      .TIME_W    (TIME_W),
      .PER_W     (PER_W),
      .IDX_W     (IDX_W)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_per   (wr_period),
      .wr_phase (wr_phase),
      .wr_cfg   (wr_cfg),
      .per_o    (per_q),
      .phase_o  (phase_q),
      .cfg_o    (cfg_q)
   );

   // time change detection
   logic [TIME_W-1:0] time_q;
   logic              tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) time_q <= '0;
      else        time_q <= time_in;
   end

   assign tick = (time_in != time_q);

   // per-slot comparison
   logic [NUM_SLOTS-1:0] pend_q;
   logic [NUM_SLOTS-1:0] hit;
   logic [NUM_SLOTS-1:0] spor_vec;

   generate
      for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_match
         assign spor_vec[s] = cfg_q[s].spor;

         tt_slot_match #(
            .TIME_W (TIME_W),
            .PER_W  (PER_W)
         ) u_match (
            .time_in (time_in),
            .tick    (tick),
            .per     (per_q[s]),
            .phase   (phase_q[s]),
            .cfg     (cfg_q[s]),
            .pend    (pend_q[s]),
            .hit     (hit[s])
         );
      end
   endgenerate

   // arbitration
   logic                 win_any;
   logic [IDX_W-1:0]     win_idx;
   logic [NUM_SLOTS-1:0] win_grant;
   logic [NUM_SLOTS-1:0] win_others;

   tt_prio_pick #(
      .N     (NUM_SLOTS),
      .IDX_W (IDX_W)
   ) u_pick (
      .req    (hit),
      .any    (win_any),
      .idx    (win_idx),
      .grant  (win_grant),
      .others (win_others)
   );

   // pending events: consumed by a sporadic win, new events take precedence
   logic [NUM_SLOTS-1:0] consume;
   assign consume = win_grant & spor_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~consume) | evt_set;
   end

   // registered outputs
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_valid <= 1'b0;
         trig_idx   <= '0;
         trig_dma   <= 1'b0;
         irq        <= 1'b0;
         conflict   <= '0;
      end else begin
         trig_valid <= win_any;
         trig_idx   <= win_idx;
         trig_dma   <= win_any && cfg_q[win_idx].dma;
         irq        <= win_any && cfg_q[win_idx].irq_en;
         conflict   <= win_others;
      end
   end

   // R4
   trig_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig_valid |-> $past(tick));

   // R9
   irq_with_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> trig_valid);

   // R8
   conflict_with_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|conflict) |-> trig_valid);

   // R8
   winner_not_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig_valid |-> !conflict[trig_idx]);

   // R10
   dma_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !trig_valid |-> !trig_dma);

   generate
      for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_pend_chk
         // R7
         pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend_q[s]) |-> $past(evt_set[s]));
      end
   endgenerate

endmodule

// File: tb/tt_sched_dispatch_bench.sv
module tt_sched_dispatch_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NS = 8;
   localparam int TW = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [TW-1:0] time_in = '0;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_idx = '0;
   logic [5:0]    wr_period = '0;
   logic [TW-1:0] wr_phase = '0;
   logic          wr_enable = 1'b0, wr_sporadic = 1'b0, wr_irq_en = 1'b0, wr_dma = 1'b0;
   logic [NS-1:0] evt_set = '0;
   logic          trig_valid, trig_dma, irq;
   logic [2:0]    trig_idx;
   logic [NS-1:0] conflict;

   always #(CLK_PERIOD/2) clk = ~clk;

   tt_sched_dispatch u_tt_sched_dispatch (
      .clk(clk), .rst_n(rst_n), .time_in(time_in),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_period(wr_period), .wr_phase(wr_phase),
      .wr_enable(wr_enable), .wr_sporadic(wr_sporadic), .wr_irq_en(wr_irq_en), .wr_dma(wr_dma),
      .evt_set(evt_set), .trig_valid(trig_valid), .trig_idx(trig_idx),
      .trig_dma(trig_dma), .irq(irq), .conflict(conflict)
   );

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // reference model state
   logic [5:0]    m_per [NS];
   logic [TW-1:0] m_ph  [NS];
   logic          m_en [NS], m_sp [NS], m_ie [NS], m_dm [NS];
   logic [NS-1:0] m_pend;
   logic [TW-1:0] m_time;

   logic          e_valid, e_dma, e_irq;
   logic [2:0]    e_idx;
   logic [NS-1:0] e_conf;

   task automatic model_reset();
      for (int i = 0; i < NS; i++) begin
         m_per[i] = '0; m_ph[i] = '0;
         m_en[i] = 0; m_sp[i] = 0; m_ie[i] = 0; m_dm[i] = 0;
      end
      m_pend = '0;
      m_time = '0;
   endtask

   // computes the expected outputs for the inputs now driven, then advances the model
   task automatic model_step();
      logic [NS-1:0] cand;
      logic [TW-1:0] mask;
      bit found;
      cand = '0;
      for (int i = 0; i < NS; i++) begin
         mask = ~({TW{1'b1}} << m_per[i]);
         cand[i] = (time_in != m_time) && m_en[i] &&
                   (((time_in ^ m_ph[i]) & mask) == '0) && (!m_sp[i] || m_pend[i]);
      end
      found = 0; e_idx = '0;
      for (int i = 0; i < NS; i++) begin
         if (cand[i] && !found) begin
            found = 1; e_idx = 3'(i);
         end
      end
      e_valid = found;
      e_dma   = found && m_dm[e_idx];
      e_irq   = found && m_ie[e_idx];
      e_conf  = cand;
      if (found) begin
         e_conf[e_idx] = 1'b0;
         if (m_sp[e_idx]) m_pend[e_idx] = 1'b0;
      end
      m_pend = m_pend | evt_set;
      m_time = time_in;
      if (wr_en) begin
         m_per[wr_idx] = wr_period; m_ph[wr_idx] = wr_phase;
         m_en[wr_idx] = wr_enable; m_sp[wr_idx] = wr_sporadic;
         m_ie[wr_idx] = wr_irq_en; m_dm[wr_idx] = wr_dma;
      end
   endtask

   // one cycle: inputs already driven at a falling edge
   task automatic cycle();
      model_step();
      @(negedge clk);
      chk("R2 R3 R6 trig_valid", 64'(trig_valid), 64'(e_valid));
      if (e_valid) chk("R8 trig_idx", 64'(trig_idx), 64'(e_idx));
      chk("R8 conflict", 64'(conflict), 64'(e_conf));
      chk("R9 irq", 64'(irq), 64'(e_irq));
      chk("R10 trig_dma", 64'(trig_dma), 64'(e_dma));
      wr_en = 1'b0;
      evt_set = '0;
   endtask

   task automatic write_slot(input int idx, input int per, input logic [TW-1:0] ph,
                             input bit en, input bit sp, input bit ie, input bit dm);
      wr_en = 1'b1; wr_idx = 3'(idx); wr_period = 6'(per); wr_phase = ph;
      wr_enable = en; wr_sporadic = sp; wr_irq_en = ie; wr_dma = dm;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20417));
      model_reset();
      repeat (3) @(negedge clk);
      // R1: outputs quiet during reset
      chk("R1 trig_valid in reset", 64'(trig_valid), 64'd0);
      chk("R1 conflict in reset", 64'(conflict), 64'd0);
      rst_n = 1'b1;
      // R1 R5: time changes with every slot disabled -> nothing fires
      time_in = 64'd1; cycle();
      chk("R1 R5 no trigger after reset", 64'(trig_valid), 64'd0);
      chk("R1 irq after reset", 64'(irq), 64'd0);

      // R11 R6: slot 2 periodic, period bit 4, phase 5, irq and dma on
      write_slot(2, 4, 64'hFFFF_0005, 1, 0, 1, 1); cycle();
      for (int t = 2; t <= 40; t++) begin
         time_in = 64'(t); cycle();
         chk("R6 periodic recurrence", 64'(trig_valid), 64'((t & 15) == 5));
         if ((t & 15) == 5) begin
            chk("R9 irq enabled slot", 64'(irq), 64'd1);
            chk("R10 dma bit", 64'(trig_dma), 64'd1);
         end
      end
      // R4: time held at a matching value -> no repeat
      time_in = 64'd37; cycle();
      chk("R4 held time after match", 64'(trig_valid), 64'd1);
      for (int k = 0; k < 3; k++) begin
         cycle();
         chk("R4 held time", 64'(trig_valid), 64'd0);
      end

      // R7: slot 5 sporadic, period bit 3, phase 2, irq off
      write_slot(5, 3, 64'd2, 1, 1, 0, 0); cycle();
      time_in = 64'd42; cycle();
      chk("R7 sporadic idle", 64'(trig_valid), 64'd0);
      evt_set = 8'h20; time_in = 64'd43; cycle();
      time_in = 64'd50; cycle();
      chk("R7 sporadic fires", 64'(trig_valid), 64'd1);
      chk("R7 sporadic index", 64'(trig_idx), 64'd5);
      chk("R9 irq off", 64'(irq), 64'd0);
      time_in = 64'd58; cycle();
      chk("R7 event consumed", 64'(trig_valid), 64'd0);

      // R8: slots 1 and 6 share an instant (period bit 2, phase 1)
      write_slot(1, 2, 64'd1, 1, 0, 0, 0); cycle();
      write_slot(6, 2, 64'd1, 1, 0, 1, 1); cycle();
      time_in = 64'd61; cycle();
      chk("R8 lowest wins", 64'(trig_idx), 64'd1);
      chk("R8 conflict mask", 64'(conflict), 64'h40);
      // R5 R11: disable slot 1, slot 6 now alone
      write_slot(1, 2, 64'd1, 0, 0, 0, 0); cycle();
      time_in = 64'd65; cycle();
      chk("R5 disabled slot skipped", 64'(trig_idx), 64'd6);
      chk("R5 no conflict", 64'(conflict), 64'd0);

      // R2: period index 0 fires on every change
      write_slot(6, 0, 64'd0, 1, 0, 0, 0); cycle();
      write_slot(2, 4, 64'd0, 0, 0, 0, 0); cycle();
      for (int t = 66; t < 70; t++) begin
         time_in = 64'(t); cycle();
         chk("R2 period zero", 64'(trig_valid), 64'd1);
      end

      // random phase
      for (int n = 0; n < 4000; n++) begin
         if ($urandom % 12 == 0)
            write_slot($urandom % NS, ($urandom % 8 == 0) ? ($urandom % 64) : ($urandom % 6),
                       {$urandom, $urandom}, ($urandom % 4) != 0, $urandom % 2,
                       $urandom % 2, $urandom % 2);
         if ($urandom % 3 == 0) evt_set = 8'($urandom);
         time_in = time_in + 64'($urandom % 3);
         cycle();
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule